// File: doc/BRIEF.md
# Nonvolatile Coefficient Store Controller

This block runs a single write of a 7-bit coefficient word into on-chip non-volatile storage. Two sources can ask for a write. The calibration sequencer hands over a word through a valid/ready stream. Software can also start a write by hand: it clears an active-low store bit after placing the word on the manual data lines. The store cell itself is a behavioural stand-in with a fixed programming time. The block reports a ready status that is low for the whole write. It also emits a one-cycle capture strobe together with the word being stored.

Every write depends on the program-enable pin. If that pin is low, a request is taken and finishes at once, with nothing written. A manual write also needs the manual-enable pin to be high; the calibration path does not.

The calibration stream follows the usual back-pressure rules. `cal_ready` equals the ready status. A transfer happens on a clock edge where both `cal_valid` and `cal_ready` are high. While ready is low, the sequencer must hold `cal_valid` and `cal_data` steady. A manual request is a single event and is not held. If it arrives while busy, it is dropped.

Top module: `nvcoef_store`

## Requirements
- R1: After reset, `ready` is 1, `cap_pulse` is 0 and `nv_word` is 0.
- R2: A 1-to-0 change of `store_n` starts a manual write of `man_data` when three conditions hold in that cycle: `ready`, `prog_en` and `man_en` are all 1. Once the write finishes, `nv_word` holds that word.
- R3: A write is accepted on some clock edge. In the cycle after that edge, `cap_pulse` is 1 for exactly one cycle and `cap_data` carries the accepted word.
- R4: `ready` is 0 for exactly PROG_CYCLES+1 cycles, starting in the cycle after acceptance. `nv_word` takes its new value in the cycle where `ready` returns to 1, and does not change while `ready` stays 1.
- R5: A request taken while `prog_en` is 0 writes nothing. It produces no `cap_pulse`, and `ready` stays 1.
- R6: A manual store edge while `man_en` is 0 has no effect.
- R7: `cal_ready` equals `ready`. A calibration word moves on an edge where both `cal_valid` and `cal_ready` are 1, and it is written if `prog_en` is 1, whatever the state of `man_en`.
- R8: A manual store edge seen while `ready` is 0 is dropped. It is not queued for later.
- R9: Holding `store_n` at 0 does not start another write; `store_n` must return to 1 first. A `store_n` that is low when reset is released does not start a write.
- R10: If a calibration transfer and a manual edge occur in the same cycle, only the calibration word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| store_n | input | 1 | Active-low manual store bit |
| man_data | input | DATA_W | Word for a manual write |
| prog_en | input | 1 | Program-enable pin; required for any write |
| man_en | input | 1 | Manual-enable pin; required for a manual write |
| cal_valid | input | 1 | Calibration word valid |
| cal_data | input | DATA_W | Calibration word |
| cal_ready | output | 1 | Calibration word accepted when high with valid |
| ready | output | 1 | 1 when idle, 0 while a write is in progress |
| cap_pulse | output | 1 | One-cycle data-capture strobe |
| cap_data | output | DATA_W | Word being stored, valid with cap_pulse |
| nv_word | output | DATA_W | Contents of the store cell |

## Verification
Manual writes are run with both enables high. They are repeated with `man_en` low and with `prog_en` low, which separates correct gating from a write that ignores the pins. A store bit held low, and store edges made while busy, check that starting a write needs a fresh edge and that requests are dropped rather than queued. Calibration words are offered both while idle and while busy, which shows the valid/ready stall. Sending both request kinds in the same cycle checks that calibration takes priority.

// File: rtl/nvcoef_pkg.sv
package nvcoef_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAPT = 2'd1,
    ST_PROG = 2'd2
  } nvcoef_state_e;
endpackage

// File: rtl/nvcoef_req.sv
module nvcoef_req #(
  parameter int DATA_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle,
  input  logic              store_n,
  input  logic [DATA_W-1:0] man_data,
  input  logic              prog_en,
  input  logic              man_en,
  input  logic              cal_valid,
  input  logic [DATA_W-1:0] cal_data,
  output logic              cal_ready,
  output logic              go,
  output logic [DATA_W-1:0] go_data
);
  logic store_prev;
  logic man_edge;
  logic cal_fire;
  logic man_fire;

  // previous store bit resets to 0 so a bit held low out of reset never fires
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) store_prev <= 1'b0;
    else        store_prev <= store_n;
  end

  assign man_edge  = store_prev & ~store_n;
  assign cal_ready = idle;
  assign cal_fire  = cal_valid & idle;
  // calibration wins a same-cycle clash; an edge while busy is consumed and lost
  assign man_fire  = man_edge & idle & ~cal_valid & man_en;
  assign go        = prog_en & (cal_fire | man_fire);
  assign go_data   = cal_fire ? cal_data : man_data;
endmodule

// File: rtl/nvcoef_ctrl.sv
module nvcoef_ctrl
  import nvcoef_pkg::*;
#(
  parameter int DATA_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [DATA_W-1:0] go_data,
  input  logic              cell_done,
  output logic              idle,
  output logic              cap_pulse,
  output logic [DATA_W-1:0] cap_data
);
  nvcoef_state_e state_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (go) begin
          state_q <= ST_CAPT;
          data_q  <= go_data;
        end
        ST_CAPT: state_q <= ST_PROG;
        ST_PROG: if (cell_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle      = (state_q == ST_IDLE);
  assign cap_pulse = (state_q == ST_CAPT);
  assign cap_data  = data_q;
endmodule

// File: rtl/nvcoef_cell.sv
module nvcoef_cell #(
  parameter int DATA_W      = 7,
  parameter int PROG_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] din,
  output logic              done,
  output logic [DATA_W-1:0] dout
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] pend_q;
  logic [DATA_W-1:0] mem_q;

  assign done = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= '0;
      mem_q  <= '0;
    end else if (start) begin
      cnt_q  <= CNT_W'(PROG_CYCLES);
      pend_q <= din;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (done) mem_q <= pend_q;
    end
  end

  assign dout = mem_q;
endmodule

// File: rtl/nvcoef_store.sv
module nvcoef_store #(
  parameter int DATA_W      = 7,
  parameter int PROG_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              store_n,
  input  logic [DATA_W-1:0] man_data,
  input  logic              prog_en,
  input  logic              man_en,
  input  logic              cal_valid,
  input  logic [DATA_W-1:0] cal_data,
  output logic              cal_ready,
  output logic              ready,
  output logic              cap_pulse,
  output logic [DATA_W-1:0] cap_data,
  output logic [DATA_W-1:0] nv_word
);
  logic              idle;
  logic              go;
  logic [DATA_W-1:0] go_data;
  logic              cell_done;

  nvcoef_req #(.DATA_W(DATA_W)) u_req (
    .clk(clk), .rst_n(rst_n), .idle(idle), .store_n(store_n),
    .man_data(man_data), .prog_en(prog_en), .man_en(man_en),
    .cal_valid(cal_valid), .cal_data(cal_data), .cal_ready(cal_ready),
    .go(go), .go_data(go_data)
  );

  nvcoef_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .go(go), .go_data(go_data),
    .cell_done(cell_done), .idle(idle), .cap_pulse(cap_pulse),
    .cap_data(cap_data)
  );

  nvcoef_cell #(.DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_cell (
    .clk(clk), .rst_n(rst_n), .start(cap_pulse), .din(cap_data),
    .done(cell_done), .dout(nv_word)
  );

  assign ready = idle;
endmodule

// File: rtl/nvcoef_store_chk.sv
module nvcoef_store_chk #(
  parameter int DATA_W      = 7,
  parameter int PROG_CYCLES = 1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prog_en,
  input logic              ready,
  input logic              cap_pulse,
  input logic [DATA_W-1:0] nv_word
);
  logic [31:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     low_cnt <= '0;
    else if (!ready) low_cnt <= low_cnt + 32'd1;
    else            low_cnt <= '0;
  end

  p_cap_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |=> !cap_pulse);

  p_cap_follows_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |-> $past(ready));

  p_busy_on_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |-> !ready);

  p_busy_length_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (low_cnt == 32'(PROG_CYCLES + 1)));

  p_word_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready)) |-> $stable(nv_word));

  p_no_cap_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !prog_en) |=> !cap_pulse);
endmodule

bind nvcoef_store nvcoef_store_chk #(.DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .ready(ready),
  .cap_pulse(cap_pulse), .nv_word(nv_word)
);

// File: tb/nvcoef_store_tb.sv
module nvcoef_store_tb;
  localparam int DW = 7;
  localparam int P  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic store_n = 1'b0;
  logic [DW-1:0] man_data = '0;
  logic prog_en = 1'b0;
  logic man_en = 1'b0;
  logic cal_valid = 1'b0;
  logic [DW-1:0] cal_data = '0;
  logic cal_ready, ready, cap_pulse;
  logic [DW-1:0] cap_data, nv_word;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  nvcoef_store #(.DATA_W(DW), .PROG_CYCLES(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .store_n(store_n), .man_data(man_data),
    .prog_en(prog_en), .man_en(man_en), .cal_valid(cal_valid),
    .cal_data(cal_data), .cal_ready(cal_ready), .ready(ready),
    .cap_pulse(cap_pulse), .cap_data(cap_data), .nv_word(nv_word)
  );

  // behavioural reference model
  int m_left = 0;
  bit m_cap = 0;
  int m_pend = 0;
  int m_word = 0;
  bit m_prev = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_left = 0; m_cap = 0; m_word = 0; m_prev = 0; m_pend = 0;
    end else begin
      bit edge_seen;
      edge_seen = m_prev && !store_n;
      m_prev = store_n;
      m_cap = 0;
      if (m_left > 0) begin
        m_left = m_left - 1;
        if (m_left == 0) m_word = m_pend;
      end else if (cal_valid) begin
        if (prog_en) begin m_left = P + 1; m_cap = 1; m_pend = int'(cal_data); end
      end else if (edge_seen && prog_en && man_en) begin
        m_left = P + 1; m_cap = 1; m_pend = int'(man_data);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk("R4 ready", int'(ready), int'(m_left == 0));
      chk("R7 cal_ready", int'(cal_ready), int'(m_left == 0));
      chk("R3 cap_pulse", int'(cap_pulse), int'(m_cap));
      if (m_cap) chk("R3 cap_data", int'(cap_data), m_pend);
      chk("R2 nv_word", int'(nv_word), m_word);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done_flag) begin
      done_flag = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!ready) @(negedge clk);
  endtask

  task automatic man_store(input logic [DW-1:0] d);
    @(negedge clk);
    store_n = 1'b1;
    man_data = d;
    cyc(2);
    store_n = 1'b0;
  endtask

  task automatic cal_send(input logic [DW-1:0] d);
    @(negedge clk);
    cal_valid = 1'b1;
    cal_data = d;
    while (!cal_ready) @(negedge clk);
    @(negedge clk);
    cal_valid = 1'b0;
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    // R1 / R9: store bit low out of reset starts nothing
    prog_en = 1'b1; man_en = 1'b1;
    cyc(4);
    chk("R1 ready after reset", int'(ready), 1);
    chk("R1 cap after reset", int'(cap_pulse), 0);
    chk("R9 no write from reset-low store bit", int'(nv_word), 0);

    // R2: manual write
    man_store(7'h55);
    cyc(1);
    chk("R2 busy after manual edge", int'(ready), 0);
    wait_idle();
    chk("R2 manual word stored", int'(nv_word), 'h55);

    // R9: held low, no retrigger
    cyc(10);
    chk("R9 ready with bit held low", int'(ready), 1);
    chk("R9 word unchanged", int'(nv_word), 'h55);

    // R8: edges while busy dropped
    man_store(7'h2A);
    cyc(3);
    store_n = 1'b1; man_data = 7'h11;
    cyc(2);
    store_n = 1'b0;
    wait_idle();
    cyc(6);
    chk("R8 busy edge not queued ready", int'(ready), 1);
    chk("R8 busy edge not queued word", int'(nv_word), 'h2A);

    // R6: manual enable low
    man_en = 1'b0;
    man_store(7'h33);
    cyc(3);
    chk("R6 no write ready", int'(ready), 1);
    chk("R6 no write word", int'(nv_word), 'h2A);

    // R5: program enable low, calibration word taken and dropped
    prog_en = 1'b0;
    cal_send(7'h44);
    cyc(3);
    chk("R5 ready stays high", int'(ready), 1);
    chk("R5 word unchanged", int'(nv_word), 'h2A);

    // R7: calibration path ignores man_en; back-pressure while busy
    prog_en = 1'b1;
    store_n = 1'b1;
    cal_send(7'h66);
    cyc(2);
    cal_send(7'h77);
    chk("R7 second word after stall busy", int'(ready), 0);
    wait_idle();
    chk("R7 stalled word stored", int'(nv_word), 'h77);

    // R10: simultaneous requests, calibration wins
    man_en = 1'b1;
    cyc(2);
    @(negedge clk);
    man_data = 7'h70; store_n = 1'b0;
    cal_valid = 1'b1; cal_data = 7'h0F;
    @(negedge clk);
    cal_valid = 1'b0;
    wait_idle();
    cyc(5);
    chk("R10 calibration word kept", int'(nv_word), 'h0F);
    chk("R10 manual edge lost", int'(ready), 1);

    cyc(2);
    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule